// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel meant to be repeated inside a multi-channel event timer. A shared free-running tick counter is brought in from outside. The channel holds a programmable 64-bit comparator and a hidden period value, and it emits a one-cycle fire pulse each time the counter reaches the comparator.

Two run modes are supported. In one-shot mode the channel fires once and then stops until it is armed again. In periodic mode the channel steps the comparator forward by the period after each match and skips over any periods the counter has already passed. A narrow mode restricts both the stored values and the comparison to the low 32 bits. In narrow one-shot mode the channel also fires once when the counter's low word wraps, provided that the wrap comes before the programmed match.

Software reaches the channel through three write strobes: one for the control bits, one for the low comparator word and one for the high comparator word. It reads back the configuration, the comparator and the period on dedicated outputs. Interrupt routing, address decode and the counter itself are outside this block.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, fire_o is 0, cmp_o is all ones, period_o is 0 and the low configuration bits read 0.
- R2: cfg_rdata_o[3:0] reads back the control bits: bit 0 is channel enable, bit 1 selects periodic mode, bit 2 is set-value and bit 3 selects narrow (32-bit) mode. Bits [31:4] read 0. Bit 32 reads 1 (periodic capable), bit 33 reads 1 (64-bit capable) and bits [63:34] return the ROUTE_CAP parameter. No write changes bits [63:32].
- R3: In one-shot mode an armed channel fires once, on the first counter value whose signed difference counter minus comparator is zero or positive. It then stays silent until it is re-armed.
- R4: In periodic mode with a non-zero period, each match adds the period to the comparator, one step per cycle, until the comparator is ahead of the counter. The whole catch-up produces a single fire, so missed periods are skipped. A periodic channel whose period is zero behaves as one-shot.
- R5: A write to either comparator word updates the comparator only when the channel is one-shot or the set-value bit is 1.
- R6: Any write to the low or high comparator word clears the set-value bit.
- R7: In periodic mode, a low-word write also loads period[31:0], with bit 31 forced to 0 in narrow mode. A high-word write that does not land in the comparator loads period[63:32] with bit 63 forced to 0.
- R8: A configuration write with bit 3 set clears the upper 32 bits of both the comparator and the period.
- R9: In narrow mode the match test uses only the low 32 bits of the counter and the comparator, and it uses a signed 32-bit difference. The comparator advance is truncated to 32 bits.
- R10: If the channel is armed in narrow one-shot mode and the comparator's low word is ahead of the counter only by wrapping through 0xFFFFFFFF, the channel fires when the counter's low word is 0xFFFFFFFF. It fires again at the real match.
- R11: A channel is armed in three cases while the global enable is 1: the enable bit goes from 0 to 1, the global enable rises while the enable bit is set, or a comparator word is written while the enable bit is set. Clearing the enable bit or dropping the global enable disarms it, and a disarmed channel never fires.
- R12: fire_o is a registered pulse. It is high in the cycle after the clock edge at which cnt_i meets the match condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 64 | Shared tick counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| cfg_we_i | input | 1 | Write strobe for the control bits |
| cfg_wdata_i | input | 4 | Control bits: narrow, set-value, periodic, enable (bit 3 to bit 0) |
| cmp_lo_we_i | input | 1 | Write strobe for the low comparator word |
| cmp_hi_we_i | input | 1 | Write strobe for the high comparator word |
| cmp_wdata_i | input | 32 | Comparator word write data |
| fire_o | output | 1 | One-cycle match pulse |
| cfg_rdata_o | output | 64 | Configuration and capability readback |
| cmp_o | output | 64 | Current comparator value |
| period_o | output | 64 | Hidden period value |

## Verification
The bench drives the counter directly, so each scenario sets the exact counter values of interest. A 64-bit one-shot sweep checks behaviour just before, at and after the comparator, which shows the pulse width and that the channel disarms after firing. A periodic walk includes a jump far past several periods; it separates a correct skip-ahead with one pulse from a design that fires once per period or stalls. A narrow one-shot run across the low-word wrap, with the counter's upper bits changed, tells the wrap fire, the narrowed compare and the final match apart. Sequences that toggle the enable bit and the global enable, and comparator writes with and without the set-value bit, check arming, the write gating and the masking of the period's top bit.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

  localparam int CNT_W  = 64;
  localparam int HALF_W = 32;

  // counter has reached comparator: signed difference cnt - cmp >= 0
  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp,
                                   input logic narrow);
    logic [CNT_W-1:0]  d;
    logic [HALF_W-1:0] d32;
    d   = cnt - cmp;
    d32 = cnt[HALF_W-1:0] - cmp[HALF_W-1:0];
    return narrow ? !d32[HALF_W-1] : !d[CNT_W-1];
  endfunction

  // one period step of the comparator, truncated in narrow mode
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] cmp,
                                               input logic [CNT_W-1:0] per,
                                               input logic narrow);
    logic [HALF_W-1:0] s32;
    s32 = cmp[HALF_W-1:0] + per[HALF_W-1:0];
    return narrow ? {{HALF_W{1'b0}}, s32} : cmp + per;
  endfunction

  // comparator is ahead of the counter only through a low-word wrap
  function automatic logic wrap_first(input logic [CNT_W-1:0] cmp,
                                      input logic [CNT_W-1:0] cnt);
    logic [HALF_W-1:0] d32;
    d32 = cmp[HALF_W-1:0] - cnt[HALF_W-1:0];
    return !d32[HALF_W-1] && (d32 != '0) && (cmp[HALF_W-1:0] < cnt[HALF_W-1:0]);
  endfunction

  // period words never keep their top bit
  function automatic logic [HALF_W-1:0] clip_top(input logic [HALF_W-1:0] v);
    return {1'b0, v[HALF_W-2:0]};
  endfunction

endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
  import evt_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [HALF_W-1:0] cmp_wdata_i,
  input  logic              adv_en_i,
  input  logic [CNT_W-1:0]  cmp_adv_i,
  output logic              en_q_o,
  output logic              per_q_o,
  output logic              setval_q_o,
  output logic              narrow_q_o,
  output logic              en_d_o,
  output logic              per_d_o,
  output logic              narrow_d_o,
  output logic [CNT_W-1:0]  cmp_q_o,
  output logic [CNT_W-1:0]  cmp_d_o,
  output logic [CNT_W-1:0]  period_q_o
);

  logic             en_q, per_q, setval_q, narrow_q;
  logic             en_d, per_d, setval_d, narrow_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, period_q, period_d;
  logic             cmp_lands;

  assign cmp_lands = !per_q || setval_q;

  always_comb begin
    en_d     = en_q;
    per_d    = per_q;
    setval_d = setval_q;
    narrow_d = narrow_q;
    cmp_d    = cmp_q;
    period_d = period_q;
    if (cfg_we_i) begin
      en_d     = cfg_wdata_i[0];
      per_d    = cfg_wdata_i[1];
      setval_d = cfg_wdata_i[2];
      narrow_d = cfg_wdata_i[3];
      if (cfg_wdata_i[3]) begin
        cmp_d[CNT_W-1:HALF_W]    = '0;
        period_d[CNT_W-1:HALF_W] = '0;
      end
    end
    if (cmp_lo_we_i) begin
      if (cmp_lands) cmp_d[HALF_W-1:0] = cmp_wdata_i;
      if (per_q)
        period_d[HALF_W-1:0] = narrow_q ? clip_top(cmp_wdata_i) : cmp_wdata_i;
      setval_d = 1'b0;
    end
    if (cmp_hi_we_i) begin
      if (cmp_lands) cmp_d[CNT_W-1:HALF_W] = cmp_wdata_i;
      else           period_d[CNT_W-1:HALF_W] = clip_top(cmp_wdata_i);
      setval_d = 1'b0;
    end
    if (!cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i && adv_en_i)
      cmp_d = cmp_adv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      setval_q <= 1'b0;
      narrow_q <= 1'b0;
      cmp_q    <= '1;
      period_q <= '0;
    end else begin
      en_q     <= en_d;
      per_q    <= per_d;
      setval_q <= setval_d;
      narrow_q <= narrow_d;
      cmp_q    <= cmp_d;
      period_q <= period_d;
    end
  end

  assign en_q_o     = en_q;
  assign per_q_o    = per_q;
  assign setval_q_o = setval_q;
  assign narrow_q_o = narrow_q;
  assign en_d_o     = en_d;
  assign per_d_o    = per_d;
  assign narrow_d_o = narrow_d;
  assign cmp_q_o    = cmp_q;
  assign cmp_d_o    = cmp_d;
  assign period_q_o = period_q;

  // R6: set-value bit clears after any comparator word write
  a_r6_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we_i || cmp_hi_we_i) |=> !setval_q);

  // R7: narrow periodic low write never leaves bit 31 of the period set
  a_r7_period_lo_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we_i && per_q && narrow_q && !cfg_we_i) |=> !period_q[HALF_W-1]);

  // R7: high write routed to the period never sets bit 63
  a_r7_period_hi_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hi_we_i && per_q && !setval_q) |=> !period_q[CNT_W-1]);

  // R8: entering narrow mode clears the upper words
  a_r8_narrow_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_wdata_i[3] && !cmp_hi_we_i) |=>
      (cmp_q[CNT_W-1:HALF_W] == '0 && period_q[CNT_W-1:HALF_W] == '0));

  // R5: blocked low write leaves the comparator low word untouched
  a_r5_cmp_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we_i && per_q && !setval_q) |=>
      (cmp_q[HALF_W-1:0] == $past(cmp_q[HALF_W-1:0])));

endmodule

// File: rtl/evt_cmp_match.sv
module evt_cmp_match
  import evt_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             glb_en_i,
  input  logic             writes_i,
  input  logic             cmp_wr_i,
  input  logic             en_q_i,
  input  logic             en_d_i,
  input  logic             per_q_i,
  input  logic             per_d_i,
  input  logic             narrow_q_i,
  input  logic             narrow_d_i,
  input  logic [CNT_W-1:0] cmp_q_i,
  input  logic [CNT_W-1:0] cmp_d_i,
  input  logic [CNT_W-1:0] period_q_i,
  output logic             adv_en_o,
  output logic [CNT_W-1:0] cmp_adv_o,
  output logic             fire_o
);

  logic armed_q, wrap_q, catch_q, glb_q, fire_q;
  logic hit, per_live, live;
  logic wrap_hit, match_now, adv_evt, arm_evt, drop_evt, fire_d;

  always_comb begin
    hit       = reached(cnt_i, cmp_q_i, narrow_q_i);
    cmp_adv_o = advance(cmp_q_i, period_q_i, narrow_q_i);
    per_live  = per_q_i && (narrow_q_i ? (period_q_i[HALF_W-1:0] != '0)
                                       : (period_q_i != '0));
    live      = armed_q && glb_en_i && !writes_i;
    wrap_hit  = live && wrap_q && (cnt_i[HALF_W-1:0] == '1);
    match_now = live && !wrap_q && hit;
    adv_evt   = match_now && per_live;
    fire_d    = wrap_hit || (match_now && !(adv_evt && catch_q));
    arm_evt   = en_d_i && glb_en_i && (!en_q_i || !glb_q || cmp_wr_i);
    drop_evt  = !en_d_i || !glb_en_i;
  end

  assign adv_en_o = adv_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      catch_q <= 1'b0;
      glb_q   <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      glb_q  <= glb_en_i;
      fire_q <= fire_d;
      if (drop_evt) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
        catch_q <= 1'b0;
      end else if (arm_evt) begin
        armed_q <= 1'b1;
        wrap_q  <= narrow_d_i && !per_d_i && wrap_first(cmp_d_i, cnt_i);
        catch_q <= 1'b0;
      end else begin
        if (wrap_hit) wrap_q <= 1'b0;
        if (live && !wrap_q) begin
          if (hit) begin
            if (adv_evt) catch_q <= reached(cnt_i, cmp_adv_o, narrow_q_i);
            else         armed_q <= 1'b0;
          end else begin
            catch_q <= 1'b0;
          end
        end
      end
    end
  end

  assign fire_o = fire_q;

  // R11: a pulse only follows a cycle in which the channel was armed and enabled
  a_r11_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(armed_q && glb_en_i));

  // R3: a one-shot match leaves the channel disarmed
  a_r3_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (match_now && !adv_evt) |=> !armed_q);

  // R10: the wrap fire consumes the wrap flag and pulses
  a_r10_wrap_fire: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> (!wrap_q && fire_q));

  // R12: nothing fires while a write is in progress
  a_r12_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    writes_i |=> !fire_q);

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter logic [29:0] ROUTE_CAP = 30'h0000_0F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              glb_en_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [HALF_W-1:0] cmp_wdata_i,
  output logic              fire_o,
  output logic [CNT_W-1:0]  cfg_rdata_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  period_o
);

  logic             en_q, per_q, setval_q, narrow_q;
  logic             en_d, per_d, narrow_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, period_q, cmp_adv;
  logic             adv_en, writes, cmp_wr;

  assign cmp_wr = cmp_lo_we_i || cmp_hi_we_i;
  assign writes = cfg_we_i || cmp_wr;

  evt_cmp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cmp_lo_we_i(cmp_lo_we_i),
    .cmp_hi_we_i(cmp_hi_we_i),
    .cmp_wdata_i(cmp_wdata_i),
    .adv_en_i   (adv_en),
    .cmp_adv_i  (cmp_adv),
    .en_q_o     (en_q),
    .per_q_o    (per_q),
    .setval_q_o (setval_q),
    .narrow_q_o (narrow_q),
    .en_d_o     (en_d),
    .per_d_o    (per_d),
    .narrow_d_o (narrow_d),
    .cmp_q_o    (cmp_q),
    .cmp_d_o    (cmp_d),
    .period_q_o (period_q)
  );

  evt_cmp_match u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .glb_en_i   (glb_en_i),
    .writes_i   (writes),
    .cmp_wr_i   (cmp_wr),
    .en_q_i     (en_q),
    .en_d_i     (en_d),
    .per_q_i    (per_q),
    .per_d_i    (per_d),
    .narrow_q_i (narrow_q),
    .narrow_d_i (narrow_d),
    .cmp_q_i    (cmp_q),
    .cmp_d_i    (cmp_d),
    .period_q_i (period_q),
    .adv_en_o   (adv_en),
    .cmp_adv_o  (cmp_adv),
    .fire_o     (fire_o)
  );

  assign cfg_rdata_o = {ROUTE_CAP, 1'b1, 1'b1, 28'd0, narrow_q, setval_q, per_q, en_q};
  assign cmp_o       = cmp_q;
  assign period_o    = period_q;

  // R2: capability half of the configuration word is constant after reset
  a_r2_caps_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> $stable(cfg_rdata_o[CNT_W-1:HALF_W]));

endmodule

// File: tb/evt_cmp_channel_test.sv
module evt_cmp_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt_i = '0;
  logic        glb_en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_wdata_i = '0;
  logic        cmp_lo_we_i = 1'b0;
  logic        cmp_hi_we_i = 1'b0;
  logic [31:0] cmp_wdata_i = '0;
  logic        fire_o;
  logic [63:0] cfg_rdata_o, cmp_o, period_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [29:0] CAPS = 30'h0000_0F00;

  // periodic walk: {counter, expected fire}; cmp 200, period 50
  localparam logic [64:0] PER_VEC [0:9] = '{
    {64'd199, 1'b0}, {64'd200, 1'b1}, {64'd201, 1'b0}, {64'd249, 1'b0},
    {64'd250, 1'b1}, {64'd420, 1'b1}, {64'd421, 1'b0}, {64'd422, 1'b0},
    {64'd449, 1'b0}, {64'd450, 1'b1}
  };

  always #5 clk = ~clk;

  evt_cmp_channel #(.ROUTE_CAP(CAPS)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .glb_en_i(glb_en_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cmp_lo_we_i(cmp_lo_we_i), .cmp_hi_we_i(cmp_hi_we_i),
    .cmp_wdata_i(cmp_wdata_i), .fire_o(fire_o),
    .cfg_rdata_o(cfg_rdata_o), .cmp_o(cmp_o), .period_o(period_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts just after a falling edge and ends on the next one
  task automatic step(input logic [63:0] v);
    cnt_i = v;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [3:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_lo(input logic [31:0] d);
    cmp_lo_we_i = 1'b1; cmp_wdata_i = d;
    @(negedge clk);
    cmp_lo_we_i = 1'b0;
  endtask

  task automatic wr_hi(input logic [31:0] d);
    cmp_hi_we_i = 1'b1; cmp_wdata_i = d;
    @(negedge clk);
    cmp_hi_we_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 capability word
    chk("R1 fire", {63'd0, fire_o}, 64'd0);
    chk("R1 cmp", cmp_o, '1);
    chk("R1 period", period_o, 64'd0);
    chk("R2 cfg", cfg_rdata_o, {CAPS, 2'b11, 32'd0});

    // R3 64-bit one-shot at 100
    glb_en_i = 1'b1;
    step(64'd0);
    wr_lo(32'd100);
    wr_hi(32'd0);
    chk("R5 oneshot write", cmp_o, 64'd100);
    wr_cfg(4'b0001);
    chk("R2 cfg low", cfg_rdata_o, {CAPS, 2'b11, 28'd0, 4'b0001});
    step(64'd98);  chk("R3 before", {63'd0, fire_o}, 64'd0);
    step(64'd99);  chk("R3 before", {63'd0, fire_o}, 64'd0);
    step(64'd100); chk("R12 match pulse", {63'd0, fire_o}, 64'd1);
    step(64'd101); chk("R12 single pulse", {63'd0, fire_o}, 64'd0);
    step(64'd100); chk("R3 no refire", {63'd0, fire_o}, 64'd0);

    // R5 R6 R7 periodic programming
    wr_cfg(4'b0000);
    wr_cfg(4'b0110);
    wr_lo(32'd200);
    chk("R6 setval cleared", {60'd0, cfg_rdata_o[3:0]}, 64'd2);
    wr_hi(32'd0);
    wr_lo(32'd50);
    chk("R5 gated cmp", cmp_o, 64'd200);
    chk("R7 period load", period_o, 64'd50);

    // R4 periodic walk with skipped periods
    step(64'd150);
    wr_cfg(4'b0011);
    for (int i = 0; i < 10; i++) begin
      step(PER_VEC[i][64:1]);
      chk("R4 periodic fire", {63'd0, fire_o}, {63'd0, PER_VEC[i][0]});
    end
    chk("R4 cmp advanced", cmp_o, 64'd500);

    // R7 period top bits, R8 narrow truncation
    wr_cfg(4'b0010);
    wr_hi(32'hFFFF_FFFF);
    chk("R7 hi msb", period_o, 64'h7FFF_FFFF_0000_0032);
    wr_cfg(4'b1010);
    chk("R8 period trunc", period_o, 64'h32);
    chk("R8 cmp trunc", cmp_o, 64'd500);
    wr_lo(32'hFFFF_FFFF);
    chk("R7 lo msb", period_o, 64'h7FFF_FFFF);
    chk("R5 cmp kept", cmp_o, 64'd500);

    // R10 R9 narrow one-shot across the wrap
    wr_cfg(4'b1000);
    wr_lo(32'h10);
    step(64'hFFFF_FFF0);
    wr_cfg(4'b1001);
    step(64'hFFFF_FFFE);   chk("R10 before wrap", {63'd0, fire_o}, 64'd0);
    step(64'hFFFF_FFFF);   chk("R10 wrap fire", {63'd0, fire_o}, 64'd1);
    step(64'h1_0000_0000); chk("R10 after wrap", {63'd0, fire_o}, 64'd0);
    step(64'h1_0000_000F); chk("R9 narrow before", {63'd0, fire_o}, 64'd0);
    step(64'h1_0000_0010); chk("R9 narrow match", {63'd0, fire_o}, 64'd1);
    step(64'h1_0000_0011); chk("R9 one-shot done", {63'd0, fire_o}, 64'd0);

    // R11 arming rules
    wr_cfg(4'b0000);
    wr_lo(32'd1000);
    wr_hi(32'd0);
    step(64'd990);
    wr_cfg(4'b0001);
    wr_cfg(4'b0000);
    step(64'd1000); chk("R11 disarmed", {63'd0, fire_o}, 64'd0);
    glb_en_i = 1'b0;
    step(64'd990);
    wr_cfg(4'b0001);
    step(64'd1000); chk("R11 global off", {63'd0, fire_o}, 64'd0);
    glb_en_i = 1'b1;
    step(64'd990);
    step(64'd1000); chk("R11 global rise arms", {63'd0, fire_o}, 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule